// File: doc/BRIEF.md
# Power-Mode Controller with Watchdog Interlock

This block holds the power control byte of a small microcontroller and turns it into clock enables for the CPU core, the serial port and each counter/timer. Software writes the byte. The block decodes three modes from it: run, idle and power-down. In idle the core clock stops while the peripherals keep running. In power-down every enable drops. A separate serial-sleep bit switches off only the serial port clock, in any mode. A timer whose run control is off loses its clock automatically.

A watchdog that is counting needs the oscillator, so the block refuses power-down while the watchdog reports it is running. A refused write still stores all its other bits. Wake events clear the mode bits: an enabled interrupt ends idle, and an external wake ends both idle and power-down. Reset clears the whole byte. The asynchronous active-low reset is released to the register through a two-stage synchronizer.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the byte reads 0x00, `core_ce` and `serial_ce` are 1, and `tmr_ce` equals `tmr_run`.
- R2: A write stores bit 7 (double rate), bit 6 (serial sleep), bit 3 (flag B), bit 2 (flag A), bit 1 (power-down) and bit 0 (idle), subject to R4, R10 and R11. The stored byte appears on `rd_data` the cycle after the write edge, and bit 7 also drives `dbl_rate`.
- R3: Bits 5 and 4 always read 0, whatever value is written to them.
- R4: A write with bit 1 set while `wdt_running` is 1 stores bit 1 as 0. The other bits of that write are stored normally.
- R5: While stored bit 1 is 1, `core_ce`, `serial_ce` and every `tmr_ce` bit are 0.
- R6: While stored bit 0 is 1 and bit 1 is 0, `core_ce` is 0 and the peripheral enables follow R8 and R9.
- R7: A write with bits 1 and 0 both set and the watchdog stopped enters power-down, not idle.
- R8: While stored bit 6 is 1, `serial_ce` is 0. When bit 6 is 0 and bit 1 is 0, `serial_ce` is 1.
- R9: Outside power-down, `tmr_ce[i]` equals `tmr_run[i]`, combinationally.
- R10: `wake_irq` clears stored bit 0 at the next edge and leaves bit 1 unchanged.
- R11: `wake_ext` clears stored bits 1 and 0 at the next edge.
- R12: A wake in the same cycle as a write takes priority over the written value of the bits that the wake clears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Byte to write |
| wdt_running | input | 1 | Watchdog is counting; blocks power-down entry |
| wake_irq | input | 1 | Enabled interrupt pending; ends idle |
| wake_ext | input | 1 | External wake; ends idle and power-down |
| tmr_run | input | NUM_TMR | Run control of each counter/timer |
| rd_data | output | 8 | Stored control byte |
| dbl_rate | output | 1 | Double baud rate bit to the serial port |
| core_ce | output | 1 | CPU core clock enable |
| serial_ce | output | 1 | Serial port clock enable |
| tmr_ce | output | NUM_TMR | Per-timer clock enables |

## Verification
A wrong stored byte shows on `rd_data` one cycle after the write edge that caused it. The clock enables follow the stored byte in the same cycle, so a fault in the mode decode or in the enable logic shows as soon as the register changes. The bench writes every byte value with the watchdog both stopped and running. After each write it compares the read-back byte and all four timer run patterns against values it computes itself. It then applies each wake and checks which mode bits it clears, so a wrong lock, a wrong precedence or a wrong wake mask shows within two cycles of the stimulus that exposes it.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  localparam int REG_W = 8;

  localparam int BIT_DBL = 7;
  localparam int BIT_SER = 6;
  localparam int BIT_FLB = 3;
  localparam int BIT_FLA = 2;
  localparam int BIT_PD  = 1;
  localparam int BIT_IDL = 0;

  localparam logic [REG_W-1:0] WR_MASK =
    (REG_W'(1) << BIT_DBL) | (REG_W'(1) << BIT_SER) |
    (REG_W'(1) << BIT_FLB) | (REG_W'(1) << BIT_FLA) |
    (REG_W'(1) << BIT_PD)  | (REG_W'(1) << BIT_IDL);

  localparam logic [REG_W-1:0] PD_MASK  = REG_W'(1) << BIT_PD;
  localparam logic [REG_W-1:0] IDL_MASK = REG_W'(1) << BIT_IDL;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_PDOWN = 2'd2
  } pwr_mode_e;

endpackage

// File: rtl/pwr_rst_sync.sv
module pwr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/pwr_ctl_reg.sv
module pwr_ctl_reg
  import pwr_mode_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             wdt_running,
  input  logic             wake_irq,
  input  logic             wake_ext,
  output logic [REG_W-1:0] ctl_q,
  output logic             pd_bit,
  output logic             idl_bit,
  output logic             ser_off
);

  logic [REG_W-1:0] ctl_d;
  logic [REG_W-1:0] wr_masked;
  logic [REG_W-1:0] wake_clr;

  // Power-down request is dropped while the watchdog runs; other bits pass.
  always_comb begin
    wr_masked = wr_data & WR_MASK;
    if (wdt_running) begin
      wr_masked = wr_masked & ~PD_MASK;
    end
  end

  // Wake sources clear mode bits and override a same-cycle write.
  always_comb begin
    wake_clr = '0;
    if (wake_irq) begin
      wake_clr = wake_clr | IDL_MASK;
    end
    if (wake_ext) begin
      wake_clr = wake_clr | IDL_MASK | PD_MASK;
    end
  end

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en) begin
      ctl_d = wr_masked;
    end
    ctl_d = ctl_d & ~wake_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else begin
      ctl_q <= ctl_d;
    end
  end

  assign pd_bit  = ctl_q[BIT_PD];
  assign idl_bit = ctl_q[BIT_IDL];
  assign ser_off = ctl_q[BIT_SER];

  p_pd_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdt_running) |=> !pd_bit);

  p_irq_wake_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |=> !idl_bit);

  p_irq_keeps_pd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_irq && !wake_ext && !wr_en) |=> (pd_bit == $past(pd_bit)));

  p_ext_wake_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wake_ext |=> (!pd_bit && !idl_bit));

endmodule

// File: rtl/pwr_mode_dec.sv
module pwr_mode_dec
  import pwr_mode_pkg::*;
(
  input  logic      pd_bit,
  input  logic      idl_bit,
  output pwr_mode_e mode
);

  // Power-down outranks idle when both bits are stored.
  always_comb begin
    if (pd_bit) begin
      mode = MODE_PDOWN;
    end else if (idl_bit) begin
      mode = MODE_IDLE;
    end else begin
      mode = MODE_RUN;
    end
  end

endmodule

// File: rtl/pwr_clk_en.sv
module pwr_clk_en
  import pwr_mode_pkg::*;
#(
  parameter int NUM_TMR = 2
) (
  input  pwr_mode_e          mode,
  input  logic               ser_off,
  input  logic [NUM_TMR-1:0] tmr_run,
  output logic               core_ce,
  output logic               serial_ce,
  output logic [NUM_TMR-1:0] tmr_ce
);

  logic periph_on;

  always_comb begin
    periph_on = (mode != MODE_PDOWN);
    core_ce   = (mode == MODE_RUN);
    serial_ce = periph_on && !ser_off;
  end

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    always_comb begin
      tmr_ce[i] = periph_on && tmr_run[i];
    end
  end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int NUM_TMR   = 2,
  parameter int RST_STAGE = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [7:0]         wr_data,
  input  logic               wdt_running,
  input  logic               wake_irq,
  input  logic               wake_ext,
  input  logic [NUM_TMR-1:0] tmr_run,
  output logic [7:0]         rd_data,
  output logic               dbl_rate,
  output logic               core_ce,
  output logic               serial_ce,
  output logic [NUM_TMR-1:0] tmr_ce
);

  logic             rst_sync_n;
  logic [REG_W-1:0] ctl_q;
  logic             pd_bit;
  logic             idl_bit;
  logic             ser_off;
  pwr_mode_e        mode;

  pwr_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  pwr_ctl_reg u_reg (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .wdt_running (wdt_running),
    .wake_irq    (wake_irq),
    .wake_ext    (wake_ext),
    .ctl_q       (ctl_q),
    .pd_bit      (pd_bit),
    .idl_bit     (idl_bit),
    .ser_off     (ser_off)
  );

  pwr_mode_dec u_dec (
    .pd_bit  (pd_bit),
    .idl_bit (idl_bit),
    .mode    (mode)
  );

  pwr_clk_en #(.NUM_TMR(NUM_TMR)) u_ce (
    .mode      (mode),
    .ser_off   (ser_off),
    .tmr_run   (tmr_run),
    .core_ce   (core_ce),
    .serial_ce (serial_ce),
    .tmr_ce    (tmr_ce)
  );

  assign rd_data  = ctl_q;
  assign dbl_rate = ctl_q[BIT_DBL];

  p_pd_all_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[BIT_PD] |-> (!core_ce && !serial_ce && (tmr_ce == '0)));

  p_idle_core_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[BIT_IDL] |-> !core_ce);

  p_pd_over_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[BIT_PD] && rd_data[BIT_IDL]) |-> !serial_ce);

  p_ser_sleep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[BIT_SER] |-> !serial_ce);

  p_tmr_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[BIT_PD] |-> (tmr_ce == tmr_run));

endmodule

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;

  localparam int CLK_P   = 10;
  localparam int NUM_TMR = 2;

  logic               clk;
  logic               rst_n;
  logic               wr_en;
  logic [7:0]         wr_data;
  logic               wdt_running;
  logic               wake_irq;
  logic               wake_ext;
  logic [NUM_TMR-1:0] tmr_run;
  logic [7:0]         rd_data;
  logic               dbl_rate;
  logic               core_ce;
  logic               serial_ce;
  logic [NUM_TMR-1:0] tmr_ce;

  int checks;
  int errors;
  bit done;

  pwr_mode_ctrl #(.NUM_TMR(NUM_TMR)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .wdt_running (wdt_running),
    .wake_irq    (wake_irq),
    .wake_ext    (wake_ext),
    .tmr_run     (tmr_run),
    .rd_data     (rd_data),
    .dbl_rate    (dbl_rate),
    .core_ce     (core_ce),
    .serial_ce   (serial_ce),
    .tmr_ce      (tmr_ce)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_store(input logic [7:0] d, input bit wdt);
    logic [7:0] v;
    v = d & 8'hCF;
    if (wdt) v[1] = 1'b0;
    return v;
  endfunction

  // Enables expected for a stored byte v and timer pattern t: {core, serial, tmr}
  function automatic logic [3:0] exp_ce(input logic [7:0] v, input logic [1:0] t);
    logic core, ser;
    logic [1:0] tm;
    core = !v[1] && !v[0];
    ser  = !v[1] && !v[6];
    tm   = v[1] ? 2'b00 : t;
    return {core, ser, tm};
  endfunction

  task automatic do_cycle(input bit we, input logic [7:0] d, input bit wdt,
                          input bit wi, input bit wx);
    @(negedge clk);
    wr_en = we; wr_data = d; wdt_running = wdt; wake_irq = wi; wake_ext = wx;
    @(negedge clk);
    wr_en = 1'b0; wake_irq = 1'b0; wake_ext = 1'b0;
    #1;
  endtask

  task automatic check_ce(input logic [7:0] v, input string tag);
    for (int t = 0; t < 4; t++) begin
      logic [3:0] e;
      tmr_run = t[1:0];
      #1;
      e = exp_ce(v, t[1:0]);
      chk({core_ce, serial_ce, tmr_ce} == e, tag, {core_ce, serial_ce, tmr_ce}, e);
    end
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; wdt_running = 1'b0;
    wake_irq = 1'b0; wake_ext = 1'b0; tmr_run = 2'b10;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(rd_data == 8'h00, "R1 reset byte", rd_data, 8'h00);
    chk(core_ce && serial_ce, "R1 reset core/serial", {core_ce, serial_ce}, 2'b11);
    chk(tmr_ce == 2'b10, "R1 reset timers", tmr_ce, 2'b10);

    // Exhaustive sweep over written byte and watchdog state
    for (int d = 0; d < 256; d++) begin
      for (int w = 0; w < 2; w++) begin
        logic [7:0] e;
        e = exp_store(d[7:0], w[0]);
        do_cycle(1'b1, d[7:0], w[0], 1'b0, 1'b0);
        chk(rd_data == e, "R2 stored byte", rd_data, e);
        chk(dbl_rate == e[7], "R2 double rate", dbl_rate, e[7]);
        chk(rd_data[5:4] == 2'b00, "R3 reserved bits", rd_data[5:4], 2'b00);
        if (w == 1 && d[1])
          chk(rd_data[1] == 1'b0, "R4 power-down refused", rd_data[1], 1'b0);
        if (e[1]) check_ce(e, "R5 power-down enables");
        else if (e[0]) check_ce(e, "R6 idle enables");
        else if (e[6]) check_ce(e, "R8 serial sleep enables");
        else check_ce(e, "R9 run enables");
        if (w == 0 && d[1:0] == 2'b11)
          chk(!core_ce && !serial_ce, "R7 power-down wins", {core_ce, serial_ce}, 2'b00);
        // interrupt wake: clears idle, keeps power-down
        do_cycle(1'b0, 8'h00, w[0], 1'b1, 1'b0);
        e = e & 8'hFE;
        chk(rd_data == e, "R10 interrupt wake", rd_data, e);
        // external wake: clears power-down
        if (e[1]) begin
          do_cycle(1'b0, 8'h00, w[0], 1'b0, 1'b1);
          e = e & 8'hFC;
          chk(rd_data == e, "R11 external wake", rd_data, e);
          check_ce(e, "R11 enables after wake");
        end
      end
    end

    // R11 external wake ends idle too
    do_cycle(1'b1, 8'h45, 1'b0, 1'b0, 1'b0);
    do_cycle(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    chk(rd_data == 8'h44, "R11 external wake from idle", rd_data, 8'h44);

    // R12 wakes in the same cycle as a write
    do_cycle(1'b1, 8'h43, 1'b0, 1'b1, 1'b0);
    chk(rd_data == 8'h42, "R12 irq wake beats write", rd_data, 8'h42);
    do_cycle(1'b1, 8'h8F, 1'b0, 1'b0, 1'b1);
    chk(rd_data == 8'h8C, "R12 ext wake beats write", rd_data, 8'h8C);
    check_ce(8'h8C, "R12 enables");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule